// File: doc/BRIEF.md
# Precise Exception Commit Unit

This block handles exceptions and interrupts for a five-stage in-order pipeline (fetch, decode, execute, memory, writeback). Each instruction carries a small fault record: a flag, a cause code and its program counter. The record moves with the instruction from stage to stage. Each stage's fault source can mark the record, but only if no earlier stage has marked it already. Nothing is acted on until the instruction reaches the commit point in the memory stage.

At commit, the block decides whether to trap. An external interrupt request wins over any synchronous fault, but only when interrupts are enabled and a real instruction occupies the commit slot. When a trap is taken, the block does the following:
- It records the cause and the faulting PC.
- It squashes every other stage, including the trapping instruction's writeback.
- It steers fetch to a fixed handler address.
- It switches to supervisor mode with interrupts masked.

A return operation at commit sends fetch back to the saved PC, re-enables interrupts and drops back to user mode.

Top module: `exc_commit_unit`

## Requirements
- R1: After reset there are no kills and no redirect. The cause and saved PC read 0, interrupts are enabled and supervisor mode is off.
- R2: A fault recorded on an instruction is acted on only when that instruction is in the memory stage. This is three clock edges after it was presented at fetch. No kill or redirect happens while it is still in an earlier stage.
- R3: When one instruction collects faults in several stages, the earliest stage's cause is the one committed.
- R4: The cause codes are 0 for a fetch address fault, 1 for an illegal opcode, 2 for an arithmetic overflow, 3 for a data address fault and 8 for an external interrupt.
- R5: In the cycle a trap commits, the following are all asserted: kill_fetch, kill_dec, kill_exe and kill_wb, together with redirect_valid and redirect_pc equal to HANDLER_PC. On the next edge, cause_q and epc_q take the trap's cause and the trapping instruction's PC.
- R6: Traps are precise. An older instruction that reached commit ahead of the trapping one still commits. Younger instructions that were in flight never commit, and their own faults are discarded.
- R7: An interrupt request is taken only if interrupts are enabled and a valid instruction is at commit. It then overrides any synchronous fault on that instruction, and that instruction's PC is saved.
- R8: Taking a trap clears intr_en and sets sup_mode. While intr_en is low, irq_req has no effect and the instruction at commit completes.
- R9: A return (mem_sret on a valid, non-trapping commit instruction) does three things. It redirects to epc_q, killing fetch, decode and execute but not writeback. It lets the return instruction commit. On the next edge it sets intr_en and clears sup_mode.
- R10: A bubble never traps. Fault inputs raised against an empty stage have no effect, and a request at an empty commit slot has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fetch_valid | input | 1 | An instruction is being fetched this cycle |
| fetch_pc | input | 32 | PC of the fetched instruction |
| fetch_fault | input | 1 | Fetch address fault on the fetched instruction |
| dec_illegal | input | 1 | Illegal opcode on the decode-stage instruction |
| exe_overflow | input | 1 | Overflow on the execute-stage instruction |
| mem_fault | input | 1 | Data address fault on the memory-stage instruction |
| mem_sret | input | 1 | Memory-stage instruction is a return from supervisor |
| irq_req | input | 1 | External interrupt request level |
| kill_fetch | output | 1 | Squash the fetch-stage instruction |
| kill_dec | output | 1 | Squash the decode-stage instruction |
| kill_exe | output | 1 | Squash the execute-stage instruction |
| kill_wb | output | 1 | Block writeback of the memory-stage instruction |
| commit_valid | output | 1 | Memory-stage instruction commits this cycle |
| commit_pc | output | 32 | PC held in the memory stage |
| redirect_valid | output | 1 | Fetch must restart at redirect_pc |
| redirect_pc | output | 32 | Handler PC on a trap, saved PC on a return |
| cause_q | output | 4 | Cause register |
| epc_q | output | 32 | Saved exception PC |
| intr_en | output | 1 | Interrupts enabled |
| sup_mode | output | 1 | Supervisor mode |

## Verification
The assertions assume that the pipeline advances one stage every cycle. They also assume that each stage's fault input refers only to the instruction that stage holds in that cycle, and that mem_sret is raised only for a real instruction at commit. The bench keeps within this in three ways:
- It changes inputs only on the falling edge.
- It lines up each stage input with the cycle in which its target instruction sits in that stage, counted from the edge at which it was fetched.
- It starts every scenario from reset, so no stale pipeline contents affect its results.

// File: rtl/exc_pkg.sv
package exc_pkg;
  localparam int PC_W    = 32;
  localparam int CAUSE_W = 4;
  localparam int NSTG    = 3;  // registered stages: decode, execute, memory

  localparam logic [CAUSE_W-1:0] C_FETCH = 4'd0;
  localparam logic [CAUSE_W-1:0] C_ILL   = 4'd1;
  localparam logic [CAUSE_W-1:0] C_OVF   = 4'd2;
  localparam logic [CAUSE_W-1:0] C_DMEM  = 4'd3;
  localparam logic [CAUSE_W-1:0] C_IRQ   = 4'd8;

  typedef struct packed {
    logic               vld;
    logic               exc;
    logic [CAUSE_W-1:0] cause;
    logic [PC_W-1:0]    pc;
  } exc_pkt_t;

  // Cause raised by the source that feeds stage boundary idx (0 fetch .. 3 memory).
  function automatic logic [CAUSE_W-1:0] src_cause(input int idx);
    return CAUSE_W'(idx);
  endfunction

  // An earlier fault wins; a bubble carries nothing.
  function automatic exc_pkt_t exc_merge(input exc_pkt_t p, input logic flag,
                                         input logic [CAUSE_W-1:0] code);
    exc_pkt_t r;
    r = p;
    if (!p.vld) begin
      r = '0;
    end else if (!p.exc && flag) begin
      r.exc   = 1'b1;
      r.cause = code;
    end
    return r;
  endfunction
endpackage

// File: rtl/exc_pipe.sv
module exc_pipe
  import exc_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            flush,
  input  exc_pkt_t        fetch_pkt,
  input  logic [NSTG-1:0] src_flag,
  output exc_pkt_t        m_pkt
);
  for (genvar g = 0; g < NSTG; g++) begin : stg
    exc_pkt_t prev;
    exc_pkt_t q;
    if (g == 0) begin : g_head
      assign prev = fetch_pkt;
    end else begin : g_link
      assign prev = stg[g-1].q;
    end
    always_ff @(posedge clk) begin
      if (!rst_n || flush) q <= '0;
      else                 q <= exc_merge(prev, src_flag[g], src_cause(g));
    end
  end

  assign m_pkt = stg[NSTG-1].q;

  // R6: a flush empties the commit slot on the following cycle
  a_r6_flush_empties: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> !m_pkt.vld);
  // R10: a bubble entering decode carries no fault
  a_r10_bubble_clean: assert property (@(posedge clk) disable iff (!rst_n)
    (!fetch_pkt.vld && !flush) |=> !stg[0].q.exc);
endmodule

// File: rtl/exc_commit.sv
module exc_commit
  import exc_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  exc_pkt_t           m_pkt,
  input  logic               mem_fault,
  input  logic               mem_sret,
  input  logic               irq_req,
  input  logic               intr_en,
  output logic               trap_take,
  output logic               sret_take,
  output logic [CAUSE_W-1:0] trap_cause,
  output logic               commit_ok
);
  exc_pkt_t fin;
  logic     irq_take;

  always_comb begin
    fin        = exc_merge(m_pkt, mem_fault, src_cause(NSTG));
    irq_take   = m_pkt.vld && irq_req && intr_en;
    trap_take  = irq_take || fin.exc;
    trap_cause = irq_take ? C_IRQ : fin.cause;
    sret_take  = m_pkt.vld && mem_sret && !trap_take;
    commit_ok  = m_pkt.vld && !trap_take;
  end

  // R10: an empty commit slot never traps or returns
  a_r10_empty_slot: assert property (@(posedge clk) disable iff (!rst_n)
    !m_pkt.vld |-> !trap_take && !sret_take);
  // R4: a committed cause is one of the defined codes
  a_r4_cause_code: assert property (@(posedge clk) disable iff (!rst_n)
    trap_take |-> (trap_cause <= C_DMEM) || (trap_cause == C_IRQ));
endmodule

// File: rtl/exc_csr.sv
module exc_csr
  import exc_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               trap_take,
  input  logic               sret_take,
  input  logic [CAUSE_W-1:0] trap_cause,
  input  logic [PC_W-1:0]    trap_pc,
  output logic [CAUSE_W-1:0] cause_q,
  output logic [PC_W-1:0]    epc_q,
  output logic               intr_en,
  output logic               sup_mode
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cause_q  <= '0;
      epc_q    <= '0;
      intr_en  <= 1'b1;
      sup_mode <= 1'b0;
    end else if (trap_take) begin
      cause_q  <= trap_cause;
      epc_q    <= trap_pc;
      intr_en  <= 1'b0;
      sup_mode <= 1'b1;
    end else if (sret_take) begin
      intr_en  <= 1'b1;
      sup_mode <= 1'b0;
    end
  end

  // R5: the saved PC is the trapping instruction's PC
  a_r5_epc_capture: assert property (@(posedge clk) disable iff (!rst_n)
    trap_take |=> epc_q == $past(trap_pc));
  // R8: a trap masks interrupts and enters supervisor mode
  a_r8_enter_sup: assert property (@(posedge clk) disable iff (!rst_n)
    trap_take |=> !intr_en && sup_mode);
  // R9: a return unmasks interrupts and leaves supervisor mode
  a_r9_leave_sup: assert property (@(posedge clk) disable iff (!rst_n)
    sret_take |=> intr_en && !sup_mode);
endmodule

// File: rtl/exc_commit_unit.sv
module exc_commit_unit
  import exc_pkg::*;
#(
  parameter logic [31:0] HANDLER_PC = 32'h0000_0080
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               fetch_valid,
  input  logic [PC_W-1:0]    fetch_pc,
  input  logic               fetch_fault,
  input  logic               dec_illegal,
  input  logic               exe_overflow,
  input  logic               mem_fault,
  input  logic               mem_sret,
  input  logic               irq_req,
  output logic               kill_fetch,
  output logic               kill_dec,
  output logic               kill_exe,
  output logic               kill_wb,
  output logic               commit_valid,
  output logic [PC_W-1:0]    commit_pc,
  output logic               redirect_valid,
  output logic [PC_W-1:0]    redirect_pc,
  output logic [CAUSE_W-1:0] cause_q,
  output logic [PC_W-1:0]    epc_q,
  output logic               intr_en,
  output logic               sup_mode
);
  exc_pkt_t           fetch_pkt, m_pkt;
  logic               trap_take, sret_take, commit_ok, flush;
  logic [CAUSE_W-1:0] trap_cause;

  always_comb begin
    fetch_pkt = '0;
    if (fetch_valid) begin
      fetch_pkt.vld = 1'b1;
      fetch_pkt.pc  = fetch_pc;
    end
  end

  assign flush = trap_take || sret_take;

  exc_pipe u_pipe (
    .clk      (clk),
    .rst_n    (rst_n),
    .flush    (flush),
    .fetch_pkt(fetch_pkt),
    .src_flag ({exe_overflow, dec_illegal, fetch_fault}),
    .m_pkt    (m_pkt)
  );

  exc_commit u_commit (
    .clk       (clk),
    .rst_n     (rst_n),
    .m_pkt     (m_pkt),
    .mem_fault (mem_fault),
    .mem_sret  (mem_sret),
    .irq_req   (irq_req),
    .intr_en   (intr_en),
    .trap_take (trap_take),
    .sret_take (sret_take),
    .trap_cause(trap_cause),
    .commit_ok (commit_ok)
  );

  exc_csr u_csr (
    .clk       (clk),
    .rst_n     (rst_n),
    .trap_take (trap_take),
    .sret_take (sret_take),
    .trap_cause(trap_cause),
    .trap_pc   (m_pkt.pc),
    .cause_q   (cause_q),
    .epc_q     (epc_q),
    .intr_en   (intr_en),
    .sup_mode  (sup_mode)
  );

  assign kill_fetch     = flush;
  assign kill_dec       = flush;
  assign kill_exe       = flush;
  assign kill_wb        = trap_take;
  assign commit_valid   = commit_ok;
  assign commit_pc      = m_pkt.pc;
  assign redirect_valid = flush;
  assign redirect_pc    = trap_take ? HANDLER_PC : epc_q;

  // R8: with interrupts masked, a request alone leaves a clean commit intact
  a_r8_masked_irq: assert property (@(posedge clk) disable iff (!rst_n)
    (!intr_en && m_pkt.vld && !m_pkt.exc && !mem_fault) |-> commit_valid);
  // R9: a return never blocks the returning instruction's writeback
  a_r9_keep_wb: assert property (@(posedge clk) disable iff (!rst_n)
    (redirect_valid && !trap_take) |-> !kill_wb && commit_valid);
endmodule

// File: tb/exc_commit_unit_bench.sv
module exc_commit_unit_bench;
  localparam logic [31:0] HPC = 32'h0000_0080;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        fetch_valid = 1'b0, fetch_fault = 1'b0, dec_illegal = 1'b0;
  logic        exe_overflow = 1'b0, mem_fault = 1'b0, mem_sret = 1'b0, irq_req = 1'b0;
  logic [31:0] fetch_pc = '0;
  logic        kill_fetch, kill_dec, kill_exe, kill_wb, commit_valid, redirect_valid;
  logic        intr_en, sup_mode;
  logic [31:0] commit_pc, redirect_pc, epc_q;
  logic [3:0]  cause_q;
  int          checks = 0, errors = 0;
  bit          done = 1'b0;

  exc_commit_unit #(.HANDLER_PC(HPC)) u_exc_commit_unit (
    .clk(clk), .rst_n(rst_n), .fetch_valid(fetch_valid), .fetch_pc(fetch_pc),
    .fetch_fault(fetch_fault), .dec_illegal(dec_illegal), .exe_overflow(exe_overflow),
    .mem_fault(mem_fault), .mem_sret(mem_sret), .irq_req(irq_req),
    .kill_fetch(kill_fetch), .kill_dec(kill_dec), .kill_exe(kill_exe), .kill_wb(kill_wb),
    .commit_valid(commit_valid), .commit_pc(commit_pc), .redirect_valid(redirect_valid),
    .redirect_pc(redirect_pc), .cause_q(cause_q), .epc_q(epc_q), .intr_en(intr_en),
    .sup_mode(sup_mode)
  );

  always #4 clk = ~clk;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // One cycle of stimulus: fetch slot plus per-stage fault inputs, settled before sampling.
  task automatic step(input logic fv, input logic [31:0] pc, input logic ff, input logic di,
                      input logic xo, input logic mf, input logic irq, input logic sr);
    @(negedge clk);
    fetch_valid = fv; fetch_pc = pc; fetch_fault = ff; dec_illegal = di;
    exe_overflow = xo; mem_fault = mf; irq_req = irq; mem_sret = sr;
    #1;
  endtask

  task automatic idle();
    step(0, 0, 0, 0, 0, 0, 0, 0);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    idle(); idle();
    @(negedge clk);
    rst_n = 1'b1;
    #1;
  endtask

  task automatic chk_trap(input string req, input logic [31:0] pc);
    chk({req, " kills"}, {kill_fetch, kill_dec, kill_exe, kill_wb}, 4'hF);
    chk({req, " redirect"}, redirect_valid, 1);
    chk({req, " handler pc"}, redirect_pc, HPC);
    chk({req, " commit pc"}, commit_pc, pc);
    chk({req, " no commit"}, commit_valid, 0);
  endtask

  // R1: reset state
  task automatic t_reset();
    do_reset();
    chk("R1 kills", {kill_fetch, kill_dec, kill_exe, kill_wb}, 0);
    chk("R1 redirect", redirect_valid, 0);
    chk("R1 cause", cause_q, 0);
    chk("R1 epc", epc_q, 0);
    chk("R1 intr_en", intr_en, 1);
    chk("R1 sup_mode", sup_mode, 0);
  endtask

  // R2, R4, R5: fetch fault travels to commit
  task automatic t_fetch_fault();
    do_reset();
    step(1, 32'h100, 1, 0, 0, 0, 0, 0);
    chk("R2 no kill at fetch", redirect_valid, 0);
    idle(); chk("R2 no kill at decode", redirect_valid, 0);
    idle(); chk("R2 no kill at execute", redirect_valid, 0);
    idle(); chk_trap("R5", 32'h100);
    idle();
    chk("R4 fetch cause 0", cause_q, 0);
    chk("R5 epc", epc_q, 32'h100);
    chk("R8 intr masked", intr_en, 0);
    chk("R8 supervisor", sup_mode, 1);
  endtask

  // R3, R4: stage priority and single-source codes
  task automatic t_prio(input string req, input logic ff, input logic di, input logic xo,
                        input logic mf, input logic [3:0] exp_cause);
    do_reset();
    step(1, 32'h200, ff, 0, 0, 0, 0, 0);
    step(0, 0, 0, di, 0, 0, 0, 0);
    step(0, 0, 0, 0, xo, 0, 0, 0);
    step(0, 0, 0, 0, 0, mf, 0, 0);
    chk({req, " trap"}, redirect_valid, 1);
    idle();
    chk({req, " cause"}, cause_q, exp_cause);
  endtask

  // R6, R10: older commits, younger flushed with their faults dropped
  task automatic t_precise();
    do_reset();
    step(1, 32'h400, 0, 0, 0, 0, 0, 0);
    step(1, 32'h404, 0, 0, 0, 0, 0, 0);
    step(1, 32'h408, 1, 1, 0, 0, 0, 0);           // B illegal in decode
    step(1, 32'h40C, 1, 0, 0, 0, 0, 0);           // A at commit
    chk("R6 older commits", commit_valid, 1);
    chk("R6 older pc", commit_pc, 32'h400);
    chk("R6 older no redirect", redirect_valid, 0);
    step(0, 0, 0, 0, 0, 0, 0, 0);                 // B at commit
    chk_trap("R6", 32'h404);
    for (int i = 0; i < 4; i++) begin
      idle();
      chk("R6 younger never commit", commit_valid, 0);
      chk("R10 flushed faults dropped", redirect_valid, 0);
    end
    chk("R6 cause kept", cause_q, 1);
    chk("R6 epc kept", epc_q, 32'h404);
  endtask

  // R7, R8, R9: interrupt gating, override and return
  task automatic t_irq_sret();
    do_reset();
    step(0, 0, 0, 0, 0, 0, 1, 0);
    chk("R7 empty slot ignores irq", redirect_valid, 0);
    step(1, 32'h500, 0, 0, 0, 0, 1, 0);
    chk("R7 irq waits for commit", redirect_valid, 0);
    step(0, 0, 0, 0, 0, 0, 1, 0);
    step(0, 0, 0, 0, 1, 0, 1, 0);
    chk("R10 empty-slot irq no effect", redirect_valid, 0);
    step(0, 0, 0, 0, 0, 1, 1, 0);                 // 0x500 at commit, also data fault
    chk_trap("R7", 32'h500);
    idle();
    chk("R7 irq overrides fault", cause_q, 8);
    chk("R7 epc", epc_q, 32'h500);
    // masked interrupts
    step(1, 32'h84, 0, 0, 0, 0, 1, 0);
    idle(); idle();
    step(0, 0, 0, 0, 0, 0, 1, 0);
    chk("R8 masked irq no redirect", redirect_valid, 0);
    chk("R8 masked irq commits", commit_valid, 1);
    // return
    step(1, 32'h88, 0, 0, 0, 0, 0, 0);
    idle(); idle();
    step(0, 0, 0, 0, 0, 0, 0, 1);
    chk("R9 redirect", redirect_valid, 1);
    chk("R9 target epc", redirect_pc, 32'h500);
    chk("R9 kills front", {kill_fetch, kill_dec, kill_exe}, 3'b111);
    chk("R9 keeps wb", kill_wb, 0);
    chk("R9 commits", commit_valid, 1);
    idle();
    chk("R9 intr_en", intr_en, 1);
    chk("R9 user mode", sup_mode, 0);
    chk("R9 cause unchanged", cause_q, 8);
  endtask

  // R10: faults raised against bubbles
  task automatic t_bubbles();
    do_reset();
    idle();
    step(0, 0, 0, 1, 0, 0, 0, 0);
    step(0, 0, 0, 0, 1, 0, 0, 0);
    step(0, 0, 0, 0, 0, 1, 0, 0);
    chk("R10 bubble no redirect", redirect_valid, 0);
    for (int i = 0; i < 3; i++) begin
      idle();
      chk("R10 bubble stays quiet", redirect_valid, 0);
    end
    chk("R10 cause untouched", cause_q, 0);
    chk("R10 mode untouched", sup_mode, 0);
  endtask

  initial begin
    t_reset();
    t_fetch_fault();
    t_prio("R3 fetch over all", 1, 1, 1, 1, 4'd0);
    t_prio("R3 illegal over data", 0, 1, 0, 1, 4'd1);
    t_prio("R4 overflow code", 0, 0, 1, 0, 4'd2);
    t_prio("R4 data fault code", 0, 0, 0, 1, 4'd3);
    t_precise();
    t_irq_sret();
    t_bubbles();
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule